// File: doc/BRIEF.md
# Phase-Shifted Multicarrier PWM Generator

This block drives the switches of one leg of a multilevel converter built from series cells or flying-capacitor cells. For an m-level leg it runs N_CAR = m-1 digital triangle carriers. All carriers share one period and one peak, and they are spread evenly in phase. Each carrier is compared against a signed reference sample, and the result drives one switch position. Because the carriers are staggered, the combined leg output steps N_CAR times per carrier period, while each device switches only once per period.

A mode input selects between two schemes. In bipolar operation every carrier spans the full signed range, and each cell gets a gate bit together with its exact complement. In unipolar operation, for H-bridge cells, even-indexed carriers span zero to the positive peak and odd-indexed carriers span zero to the negative peak. Each switch is then decided on its own, and the complement outputs stay low.

A two-state sequencer controls the carriers. After reset, in S_INIT, it preloads the carrier counters with staggered start values and captures the period setting; it then moves to S_RUN on the next edge. While in S_RUN it stays there as long as the period input matches the captured value. A different period value sends it back to S_INIT for one cycle, which restarts all carriers with the new spacing.

Top module: `shifted_carrier_pwm`

## Requirements
- R1: While reset is asserted, and in every cycle the sequencer spends in S_INIT, all gate and gate_n bits are 0.
- R2: Carrier k is a triangle that counts 0..P..0 with P = per_in, so its period is 2P cycles. Its phase leads carrier 0 by k*2P/N_CAR cycles. The period setting must make 2P a multiple of N_CAR, with P >= 2.
- R3: In bipolar mode (mode_in = 0), carrier k as seen by the comparator is 2v-P, covering -P..+P. gate[k] is 1 when the latched reference is strictly greater than this carrier value, and gate_n[k] is the exact complement of gate[k].
- R4: In unipolar mode (mode_in = 1), even-indexed carriers take the value v (0..+P) and odd-indexed carriers take -v (0..-P). gate[k] is 1 when the latched reference is strictly greater than the carrier, and gate_n is held at 0.
- R5: Each cell captures ref_in and mode_in only in S_INIT or on an edge where its own carrier sits at 0 or at P. A reference change at any other time has no effect on that gate until the carrier next reaches an extreme.
- R6: A latched reference at or above the top of a carrier's span holds that gate at 1 for the whole period. A reference at or below the bottom of the span holds it at 0. Neither case produces any glitch.
- R7: In bipolar mode with a reference strictly inside (-P, +P), each gate rises exactly once per carrier period.
- R8: If per_in differs from the captured period while in S_RUN, the next cycle is in S_INIT with all gates at 0. The carriers then restart from their staggered start values for the new period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| per_in | input | CW | Carrier half period P in clock cycles (carrier peak value) |
| ref_in | input | CW+2 | Signed reference sample, full scale is +/-P |
| mode_in | input | 1 | 0 = bipolar, 1 = unipolar |
| gate | output | N_CAR | Main switch gate per carrier |
| gate_n | output | N_CAR | Complement switch gate per carrier (bipolar only, else 0) |

## Verification
The assertions assume that the period setting is even, at least 2, and makes 2P divisible by the carrier count. They also assume that per_in changes only when a carrier restart is intended. The stimulus draws only even periods between 4 and 40, and it changes the period only at segment boundaries. Reference values are random within a band slightly wider than +/-P, mixed with exact and beyond-full-scale values, and are held for random lengths so that changes fall both at carrier extremes and between them. Directed cases measure the rise times of the gates to confirm the phase spacing, and they change the reference in the middle of a half period.

// File: rtl/scpwm_pkg.sv
package scpwm_pkg;

    typedef enum logic [0:0] {
        S_INIT = 1'b0,
        S_RUN  = 1'b1
    } seq_state_e;

    localparam logic MODE_BIPOLAR  = 1'b0;
    localparam logic MODE_UNIPOLAR = 1'b1;

endpackage

// File: rtl/scpwm_seq.sv
module scpwm_seq
    import scpwm_pkg::*;
#(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] per_in,
    output logic [CW-1:0] per_q,
    output logic          load,
    output logic          run
);

    seq_state_e state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_INIT: state_d = S_RUN;
            S_RUN:  state_d = (per_in != per_q) ? S_INIT : S_RUN;
            default: state_d = S_INIT;
        endcase
    end

    // state register and captured period
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_INIT;
            per_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_INIT) per_q <= per_in;
        end
    end

    // outputs
    always_comb begin
        load = 1'b0;
        run  = 1'b0;
        unique case (state_q)
            S_INIT: load = 1'b1;
            S_RUN:  run  = 1'b1;
            default: load = 1'b1;
        endcase
    end

endmodule

// File: rtl/scpwm_carrier.sv
module scpwm_carrier #(
    parameter int CW    = 10,
    parameter int N_CAR = 4,
    parameter int K     = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step,
    input  logic [CW-1:0] per_ld,
    input  logic [CW-1:0] per_run,
    output logic [CW-1:0] v,
    output logic          at_ext
);

    localparam int PW = CW + 1;
    localparam int MW = PW + $clog2(N_CAR) + 1;

    logic [PW-1:0] twop;
    logic [MW-1:0] prod;
    logic [MW-1:0] ph_full;
    logic [PW-1:0] ph;
    logic [CW-1:0] start_v;
    logic          start_up;
    logic          up_q;

    // staggered preload: phase offset K*2P/N_CAR
    always_comb begin
        twop     = {per_ld, 1'b0};
        prod     = MW'(K) * MW'(twop);
        ph_full  = prod / MW'(N_CAR);
        ph       = PW'(ph_full);
        start_up = (ph < {1'b0, per_ld});
        if (ph <= {1'b0, per_ld}) start_v = CW'(ph);
        else                      start_v = CW'(twop - ph);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v    <= '0;
            up_q <= 1'b1;
        end else if (load) begin
            v    <= start_v;
            up_q <= start_up;
        end else if (step) begin
            if (up_q) begin
                v <= v + CW'(1);
                if ((v + CW'(1)) == per_run) up_q <= 1'b0;
            end else begin
                v <= v - CW'(1);
                if ((v - CW'(1)) == '0) up_q <= 1'b1;
            end
        end
    end

    assign at_ext = (v == '0) || (v == per_run);

endmodule

// File: rtl/scpwm_cell.sv
module scpwm_cell
    import scpwm_pkg::*;
#(
    parameter int CW = 10,
    parameter int K  = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic                 run,
    input  logic [CW-1:0]        per_q,
    input  logic [CW-1:0]        v,
    input  logic                 at_ext,
    input  logic signed [CW+1:0] ref_in,
    input  logic                 mode_in,
    output logic signed [CW+1:0] ref_q,
    output logic                 mode_q,
    output logic                 gate,
    output logic                 gate_n
);

    localparam int  SW  = CW + 3;
    localparam bit  NEG = (K % 2) == 1;

    logic signed [SW-1:0] v_s, p_s, r_s, car_s, up_s, lo_s;
    logic                 cmp;

    // reference capture only at carrier extremes or restart
    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q  <= '0;
            mode_q <= MODE_BIPOLAR;
        end else if (load || (run && at_ext)) begin
            ref_q  <= ref_in;
            mode_q <= mode_in;
        end
    end

    always_comb begin
        v_s = signed'({3'b000, v});
        p_s = signed'({3'b000, per_q});
        r_s = {ref_q[CW+1], ref_q};
        if (mode_q == MODE_BIPOLAR) begin
            car_s = (v_s <<< 1) - p_s;
            up_s  = p_s;
            lo_s  = -p_s;
        end else if (NEG) begin
            car_s = -v_s;
            up_s  = '0;
            lo_s  = -p_s;
        end else begin
            car_s = v_s;
            up_s  = p_s;
            lo_s  = '0;
        end
        if (r_s >= up_s)      cmp = 1'b1;
        else if (r_s <= lo_s) cmp = 1'b0;
        else                  cmp = (r_s > car_s);
        gate   = run & cmp;
        gate_n = run & (mode_q == MODE_BIPOLAR) & ~cmp;
    end

endmodule

// File: rtl/shifted_carrier_pwm.sv
module shifted_carrier_pwm
    import scpwm_pkg::*;
#(
    parameter int N_CAR = 4,
    parameter int CW    = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [CW-1:0]        per_in,
    input  logic signed [CW+1:0] ref_in,
    input  logic                 mode_in,
    output logic [N_CAR-1:0]     gate,
    output logic [N_CAR-1:0]     gate_n
);

    localparam int RW = CW + 2;

    logic [CW-1:0]               per_q;
    logic                        load;
    logic                        run;
    logic [N_CAR-1:0][CW-1:0]    car_v;
    logic [N_CAR-1:0]            car_ext;
    logic [N_CAR-1:0][RW-1:0]    ref_lat;
    logic [N_CAR-1:0]            mode_lat;

    scpwm_seq #(.CW(CW)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .per_in (per_in),
        .per_q  (per_q),
        .load   (load),
        .run    (run)
    );

    for (genvar gk = 0; gk < N_CAR; gk++) begin : g_leg
        logic signed [RW-1:0] ref_k;

        scpwm_carrier #(.CW(CW), .N_CAR(N_CAR), .K(gk)) u_car (
            .clk     (clk),
            .rst     (rst),
            .load    (load),
            .step    (run),
            .per_ld  (per_in),
            .per_run (per_q),
            .v       (car_v[gk]),
            .at_ext  (car_ext[gk])
        );

        scpwm_cell #(.CW(CW), .K(gk)) u_cell (
            .clk     (clk),
            .rst     (rst),
            .load    (load),
            .run     (run),
            .per_q   (per_q),
            .v       (car_v[gk]),
            .at_ext  (car_ext[gk]),
            .ref_in  (ref_in),
            .mode_in (mode_in),
            .ref_q   (ref_k),
            .mode_q  (mode_lat[gk]),
            .gate    (gate[gk]),
            .gate_n  (gate_n[gk])
        );

        assign ref_lat[gk] = ref_k;
    end

endmodule

// File: rtl/shifted_carrier_pwm_chk.sv
module shifted_carrier_pwm_chk #(
    parameter int N_CAR = 4,
    parameter int CW    = 10
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     load,
    input logic                     run,
    input logic [CW-1:0]            per_in,
    input logic [CW-1:0]            per_q,
    input logic [N_CAR-1:0][CW-1:0] car_v,
    input logic [N_CAR-1:0]         car_ext,
    input logic [N_CAR-1:0][CW+1:0] ref_lat,
    input logic [N_CAR-1:0]         mode_lat,
    input logic [N_CAR-1:0]         gate,
    input logic [N_CAR-1:0]         gate_n
);

    p_init_off_r1: assert property (@(posedge clk) disable iff (rst)
        load |-> (gate == '0) && (gate_n == '0));

    p_restart_r8: assert property (@(posedge clk) disable iff (rst)
        (run && (per_in != per_q)) |=> load);

    for (genvar gk = 0; gk < N_CAR; gk++) begin : g_chk
        p_span_r2: assert property (@(posedge clk) disable iff (rst)
            car_v[gk] <= per_q);

        p_step_r2: assert property (@(posedge clk) disable iff (rst)
            run |=> (({1'b0, car_v[gk]} == ({1'b0, $past(car_v[gk])} + 1'b1)) ||
                     (({1'b0, car_v[gk]} + 1'b1) == {1'b0, $past(car_v[gk])})));

        p_hold_r5: assert property (@(posedge clk) disable iff (rst)
            (run && !car_ext[gk]) |=> $stable(ref_lat[gk]) && $stable(mode_lat[gk]));

        p_fullscale_r6: assert property (@(posedge clk) disable iff (rst)
            (run && !mode_lat[gk] &&
             ($signed(ref_lat[gk]) >= $signed({2'b00, per_q}))) |-> gate[gk]);

        p_uni_low_r4: assert property (@(posedge clk) disable iff (rst)
            (run && mode_lat[gk]) |-> !gate_n[gk]);
    end

endmodule

bind shifted_carrier_pwm shifted_carrier_pwm_chk #(.N_CAR(N_CAR), .CW(CW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .run      (run),
    .per_in   (per_in),
    .per_q    (per_q),
    .car_v    (car_v),
    .car_ext  (car_ext),
    .ref_lat  (ref_lat),
    .mode_lat (mode_lat),
    .gate     (gate),
    .gate_n   (gate_n)
);

// File: tb/shifted_carrier_pwm_tb.sv
module shifted_carrier_pwm_tb;

    localparam int N  = 4;
    localparam int CW = 10;
    localparam int RW = CW + 2;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic [CW-1:0]        per_in = CW'(8);
    logic signed [RW-1:0] ref_in = '0;
    logic                 mode_in = 1'b0;
    logic [N-1:0]         gate;
    logic [N-1:0]         gate_n;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    // bench model state
    bit mrun;
    int mperq;
    int mv   [N];
    bit mup  [N];
    int mref [N];
    bit mmode[N];

    always #2 clk = ~clk;

    shifted_carrier_pwm #(.N_CAR(N), .CW(CW)) u_dut (
        .clk     (clk),
        .rst     (rst),
        .per_in  (per_in),
        .ref_in  (ref_in),
        .mode_in (mode_in),
        .gate    (gate),
        .gate_n  (gate_n)
    );

    function automatic bit exp_gate(int k, int v, int r, bit md, int p);
        int car, up, lo;
        if (!md) begin
            car = 2 * v - p; up = p; lo = -p;
        end else if ((k % 2) == 1) begin
            car = -v; up = 0; lo = -p;
        end else begin
            car = v; up = p; lo = 0;
        end
        if (r >= up) return 1'b1;
        if (r <= lo) return 1'b0;
        return r > car;
    endfunction

    // reference model, advanced on each rising edge
    always @(posedge clk) begin
        if (rst) begin
            mrun = 1'b0; mperq = 0;
            for (int k = 0; k < N; k++) begin
                mv[k] = 0; mup[k] = 1'b1; mref[k] = 0; mmode[k] = 1'b0;
            end
        end else if (!mrun) begin
            mperq = int'(per_in);
            for (int k = 0; k < N; k++) begin
                int ph;
                ph = (k * 2 * mperq) / N;
                mv[k]  = (ph <= mperq) ? ph : 2 * mperq - ph;
                mup[k] = (ph < mperq);
                mref[k] = int'(ref_in);
                mmode[k] = mode_in;
            end
            mrun = 1'b1;
        end else begin
            for (int k = 0; k < N; k++) begin
                if (mv[k] == 0 || mv[k] == mperq) begin
                    mref[k] = int'(ref_in);
                    mmode[k] = mode_in;
                end
                if (mup[k]) begin
                    mv[k]++;
                    if (mv[k] == mperq) mup[k] = 1'b0;
                end else begin
                    mv[k]--;
                    if (mv[k] == 0) mup[k] = 1'b1;
                end
            end
            if (int'(per_in) != mperq) mrun = 1'b0;
        end
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // compare all outputs against the model (called at falling edge)
    task automatic compare_all();
        for (int k = 0; k < N; k++) begin
            bit eg, eg_n;
            string tag;
            eg   = mrun ? exp_gate(k, mv[k], mref[k], mmode[k], mperq) : 1'b0;
            eg_n = (mrun && !mmode[k]) ? ~exp_gate(k, mv[k], mref[k], mmode[k], mperq) : 1'b0;
            if (!mrun) tag = "R1";
            else if (mref[k] >= mperq || mref[k] <= -mperq) tag = "R6";
            else if (mmode[k]) tag = "R4";
            else tag = "R3";
            chk(gate[k] == eg, {tag, " gate"}, int'(gate[k]), int'(eg));
            chk(gate_n[k] == eg_n, {tag, " gate_n"}, int'(gate_n[k]), int'(eg_n));
        end
    endtask

    task automatic tick();
        @(negedge clk);
        compare_all();
    endtask

    task automatic set_ref(int r);
        ref_in = RW'(r);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int rise_t[N];
        int rise_n[N];
        bit prev[N];
        void'($urandom(32'd20240611));

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(gate == '0, "R1 reset gate", int'(gate), 0);
        chk(gate_n == '0, "R1 reset gate_n", int'(gate_n), 0);
        rst = 1'b0;

        // R2 / R7: bipolar, ref = 0, phase spacing and one rise per period
        per_in = CW'(8); mode_in = 1'b0; set_ref(0);
        repeat (40) tick();
        for (int k = 0; k < N; k++) begin
            rise_n[k] = 0; rise_t[k] = -1; prev[k] = gate[k];
        end
        for (int i = 0; i < 16; i++) begin
            tick();
            for (int k = 0; k < N; k++) begin
                if (!prev[k] && gate[k]) begin
                    rise_n[k]++;
                    if (rise_t[k] < 0) rise_t[k] = i;
                end
                prev[k] = gate[k];
            end
        end
        for (int k = 0; k < N; k++) begin
            chk(rise_n[k] == 1, "R7 rises per period", rise_n[k], 1);
            chk(((rise_t[0] - rise_t[k] + 16) % 16) == k * 16 / N,
                "R2 phase offset", (rise_t[0] - rise_t[k] + 16) % 16, k * 16 / N);
        end

        // R6: full scale, bipolar and unipolar
        set_ref(8);
        repeat (10) tick();
        for (int i = 0; i < 16; i++) begin
            tick();
            chk(gate == '1, "R6 bipolar +FS const", int'(gate), 15);
        end
        set_ref(-11);
        repeat (10) tick();
        for (int i = 0; i < 16; i++) begin
            tick();
            chk(gate == '0, "R6 bipolar -FS const", int'(gate), 0);
        end
        mode_in = 1'b1; set_ref(0);
        repeat (10) tick();
        for (int i = 0; i < 16; i++) begin
            tick();
            chk(gate == 4'b1010, "R6 unipolar zero ref", int'(gate), 10);
            chk(gate_n == '0, "R4 unipolar gate_n low", int'(gate_n), 0);
        end

        // R5: reference change mid half-period has no effect
        mode_in = 1'b0; set_ref(-8);
        repeat (20) tick();
        while (!(mrun && mup[0] && mv[0] == 2)) tick();
        set_ref(7);
        tick();
        chk(gate[0] == 1'b0, "R5 mid-half change ignored", int'(gate[0]), 0);
        tick();
        chk(gate[0] == 1'b0, "R5 mid-half change ignored", int'(gate[0]), 0);

        // R8: period change restarts through S_INIT
        per_in = CW'(12);
        tick();
        chk(gate == '0, "R8 restart gate", int'(gate), 0);
        chk(gate_n == '0, "R8 restart gate_n", int'(gate_n), 0);
        repeat (30) tick();

        // random segments
        for (int s = 0; s < 14; s++) begin
            int p;
            p = 2 * int'($urandom_range(2, 20));
            per_in  = CW'(p);
            mode_in = 1'($urandom_range(0, 1));
            for (int c = 0; c < 300; ) begin
                int hold, r, sel;
                sel = int'($urandom_range(0, 9));
                case (sel)
                    0: r = p;
                    1: r = -p;
                    2: r = p + 3;
                    3: r = -p - 3;
                    default: r = int'($urandom_range(0, 2 * p + 8)) - p - 4;
                endcase
                set_ref(r);
                hold = int'($urandom_range(1, 25));
                repeat (hold) tick();
                c += hold;
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule